// File: doc/BRIEF.md
# Write Leveling Sweep Controller

This block runs the strobe-to-clock alignment search on the controller side of a DDR4 memory interface. When asked to start, it writes mode register 1 to put the memory into leveling mode, with the output buffers kept enabled, and it raises on-die termination. It then walks a delay-tap select upward from zero. At each tap it fires single-cycle strobe pulses. After each pulse it waits a fixed feedback latency and samples one returned data line, which reads 0 when the strobe landed while the clock was low and 1 when it landed while the clock was high.

A tap's reading counts only once a configurable run of consecutive identical samples has been seen. This rejects jitter near the clock edge. The search ends at the first tap whose qualified reading is 1 after an earlier tap read 0, and that tap is recorded. The clock phase is never touched; only the strobe delay moves. A settle wait follows every mode register write and every tap change. After the search the block writes mode register 1 again to leave leveling mode, drops termination and reports completion. An error flag marks a sweep that ran to the top tap without finding a rising transition.

Top module: `wl_sweep_ctrl`

## Requirements
- R1: After reset, done_o, err_o, cmd_valid_o, odt_o and strobe_o are 0, and tap_o and found_tap_o are 0.
- R2: The first command after start_i is a write to mode register number 1 (cmd_mr_o = 1) with address bit 7 = 1 and address bit 12 = 0.
- R3: The last command before done_o rises is a write to mode register 1 with address bit 7 = 0 and bit 12 = 0. Exactly two commands are issued per run.
- R4: odt_o is high whenever strobe_o is high, and is low whenever a command is issued.
- R5: strobe_o is a single-cycle pulse, and tap_o is unchanged on the cycle of a pulse.
- R6: Feedback is sampled no earlier than FB_DLY cycles after the most recent strobe pulse.
- R7: No strobe pulse is issued within SETTLE cycles of a command or of a change of tap_o.
- R8: A tap's reading is taken only after QUAL consecutive identical samples. With clean feedback each visited tap costs exactly QUAL pulses, and a single disagreeing sample restarts the run.
- R9: tap_o starts at 0 and only steps up by one. The recorded tap is the first tap whose qualified reading is 1 after some earlier tap read 0.
- R10: If no 0-to-1 transition is found by tap MAX_TAP, err_o is 1 and done_o still rises. All taps 0..MAX_TAP are visited in this case.
- R11: done_o, err_o and found_tap_o hold their values until the next start_i, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a leveling run (accepted when idle or done) |
| done_o | output | 1 | Run complete, held until next start |
| err_o | output | 1 | No rising transition found |
| found_tap_o | output | TAP_W | Recorded tap of the 0-to-1 transition |
| cmd_valid_o | output | 1 | Mode register write request, one cycle |
| cmd_mr_o | output | 3 | Mode register number (always 1) |
| cmd_addr_o | output | ADDR_W | Mode register write data on the address bus |
| odt_o | output | 1 | Termination enable |
| tap_o | output | TAP_W | Delay tap select |
| strobe_o | output | 1 | Single strobe pulse request |
| fb_i | input | 1 | Sampled feedback from the data line |

## Verification
A wrong state or counter here shows up at the ports within one run. A bad tap counter or transition flag gives a found_tap_o that differs from the bench's feedback edge, or the wrong error verdict. A broken qualifier changes the number of strobe pulses per tap, which the bench counts exactly. Timer faults show as a strobe inside a settle window or an early sample, and these are flagged on the first pulse after the fault. Sweeping the feedback edge over every tap, plus the cases with no edge and with a rising edge at tap zero, plus one injected noisy sample, exercises every decision path.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_MR_EN, ST_SET_EN, ST_PULSE, ST_WAIT,
    ST_SET_TAP, ST_MR_DIS, ST_SET_DIS, ST_DONE
  } wl_state_e;

  localparam logic [2:0] MR_LVL_NUM = 3'd1;
  localparam int         LVL_BIT    = 7;   // leveling enable bit
  localparam int         QOFF_BIT   = 12;  // output-off bit, kept 0
endpackage

// File: rtl/wl_timer.sv
module wl_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] val,
  output logic             zero
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/wl_qualifier.sv
module wl_qualifier #(
  parameter int QUAL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic smp_en,
  input  logic fb,
  output logic vld,
  output logic val
);
  localparam int CNT_W = $clog2(QUAL + 1);

  logic             last_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             match;

  assign match  = (cnt_q != '0) && (fb == last_q);
  assign cnt_nx = match ? cnt_q + 1'b1 : CNT_W'(1);
  assign vld    = smp_en && (cnt_nx == CNT_W'(QUAL));
  assign val    = fb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (clr || vld) begin
      cnt_q  <= '0;
    end else if (smp_en) begin
      cnt_q  <= cnt_nx;
      last_q <= fb;
    end
  end
endmodule

// File: rtl/wl_sweep_ctrl.sv
module wl_sweep_ctrl
  import wl_pkg::*;
#(
  parameter int TAP_W   = 5,
  parameter int MAX_TAP = 31,
  parameter int FB_DLY  = 8,
  parameter int SETTLE  = 16,
  parameter int QUAL    = 4,
  parameter int ADDR_W  = 14,
  parameter int TMR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              done_o,
  output logic              err_o,
  output logic [TAP_W-1:0]  found_tap_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_mr_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              odt_o,
  output logic [TAP_W-1:0]  tap_o,
  output logic              strobe_o,
  input  logic              fb_i
);
  localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(MAX_TAP);
  localparam logic [TMR_W-1:0] T_SET    = TMR_W'(SETTLE);
  localparam logic [TMR_W-1:0] T_FB     = TMR_W'(FB_DLY);

  wl_state_e        st_q, st_d;
  logic [TAP_W-1:0] tap_q, tap_d, found_q, found_d;
  logic             seen0_q, seen0_d, err_q, err_d, done_q, done_d;
  logic             tmr_load, tmr_zero, smp_en, q_clr, q_vld, q_val;
  logic [TMR_W-1:0] tmr_val;

  wl_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  wl_qualifier #(.QUAL(QUAL)) u_qual (
    .clk(clk), .rst_n(rst_n), .clr(q_clr), .smp_en(smp_en), .fb(fb_i),
    .vld(q_vld), .val(q_val)
  );

  always_comb begin
    st_d     = st_q;
    tap_d    = tap_q;
    found_d  = found_q;
    seen0_d  = seen0_q;
    err_d    = err_q;
    done_d   = done_q;
    tmr_load = 1'b0;
    tmr_val  = T_SET;
    smp_en   = 1'b0;
    q_clr    = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          st_d    = ST_MR_EN;
          tap_d   = '0;
          found_d = '0;
          seen0_d = 1'b0;
          err_d   = 1'b0;
          done_d  = 1'b0;
          q_clr   = 1'b1;
        end
      end
      ST_MR_EN: begin
        tmr_load = 1'b1;
        st_d     = ST_SET_EN;
      end
      ST_SET_EN, ST_SET_TAP: begin
        if (tmr_zero) st_d = ST_PULSE;
      end
      ST_PULSE: begin
        tmr_load = 1'b1;
        tmr_val  = T_FB;
        st_d     = ST_WAIT;
      end
      ST_WAIT: begin
        if (tmr_zero) begin
          smp_en = 1'b1;
          if (!q_vld) begin
            st_d = ST_PULSE;
          end else if (q_val && seen0_q) begin
            found_d = tap_q;
            st_d    = ST_MR_DIS;
          end else begin
            seen0_d = seen0_q | ~q_val;
            if (tap_q == TAP_LAST) begin
              err_d = 1'b1;
              st_d  = ST_MR_DIS;
            end else begin
              tap_d    = tap_q + 1'b1;
              q_clr    = 1'b1;
              tmr_load = 1'b1;
              st_d     = ST_SET_TAP;
            end
          end
        end
      end
      ST_MR_DIS: begin
        tmr_load = 1'b1;
        st_d     = ST_SET_DIS;
      end
      ST_SET_DIS: begin
        if (tmr_zero) begin
          done_d = 1'b1;
          st_d   = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tap_q   <= '0;
      found_q <= '0;
      seen0_q <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      tap_q   <= tap_d;
      found_q <= found_d;
      seen0_q <= seen0_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    cmd_addr_o = '0;
    cmd_addr_o[LVL_BIT]  = (st_q == ST_MR_EN);
    cmd_addr_o[QOFF_BIT] = 1'b0;
  end

  assign cmd_valid_o = (st_q == ST_MR_EN) || (st_q == ST_MR_DIS);
  assign cmd_mr_o    = MR_LVL_NUM;
  assign odt_o       = (st_q == ST_SET_EN) || (st_q == ST_PULSE) ||
                       (st_q == ST_WAIT)   || (st_q == ST_SET_TAP);
  assign strobe_o    = (st_q == ST_PULSE);
  assign tap_o       = tap_q;
  assign found_tap_o = found_q;
  assign err_o       = err_q;
  assign done_o      = done_q;
endmodule

// File: rtl/wl_sweep_ctrl_chk.sv
module wl_sweep_ctrl_chk #(
  parameter int TAP_W  = 5,
  parameter int FB_DLY = 8,
  parameter int SETTLE = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic             err_o,
  input logic             cmd_valid_o,
  input logic [13:0]      cmd_addr_o,
  input logic             odt_o,
  input logic [TAP_W-1:0] tap_o,
  input logic             strobe_o,
  input logic             smp_en
);
  logic [15:0]      since_pulse, since_evt;
  logic [TAP_W-1:0] tap_prev;
  logic             tap_moved;

  assign tap_moved = (tap_o != tap_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pulse <= '0;
      since_evt   <= '0;
      tap_prev    <= '0;
    end else begin
      tap_prev    <= tap_o;
      since_pulse <= strobe_o ? 16'd0 :
                     (since_pulse == 16'hFFFF ? since_pulse : since_pulse + 16'd1);
      since_evt   <= (cmd_valid_o || tap_moved) ? 16'd0 :
                     (since_evt == 16'hFFFF ? since_evt : since_evt + 16'd1);
    end
  end

  // R2
  cmd_qoff_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> !cmd_addr_o[12]);
  // R4
  odt_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> odt_o);
  // R4
  odt_off_at_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> !odt_o);
  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
  // R5
  strobe_tap_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> !tap_moved);
  // R6
  fb_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |-> (since_pulse >= 16'(FB_DLY)));
  // R7
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> (since_evt >= 16'(SETTLE)));
  // R9
  tap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_moved |-> (tap_o == tap_prev + 1'b1) || (tap_o == '0));
  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(err_o)));
endmodule

bind wl_sweep_ctrl wl_sweep_ctrl_chk #(
  .TAP_W(TAP_W), .FB_DLY(FB_DLY), .SETTLE(SETTLE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .err_o(err_o),
  .cmd_valid_o(cmd_valid_o), .cmd_addr_o(cmd_addr_o), .odt_o(odt_o),
  .tap_o(tap_o), .strobe_o(strobe_o), .smp_en(smp_en)
);

// File: tb/wl_sweep_ctrl_tb.sv
module wl_sweep_ctrl_tb;
  localparam int CLK_P   = 10;
  localparam int TAP_W   = 3;
  localparam int MAX_TAP = 6;
  localparam int FB_DLY  = 3;
  localparam int SETTLE  = 4;
  localparam int QUAL    = 2;

  logic             clk, rst_n, start_i, fb_i;
  logic             done_o, err_o, cmd_valid_o, odt_o, strobe_o;
  logic [TAP_W-1:0] found_tap_o, tap_o;
  logic [2:0]       cmd_mr_o;
  logic [13:0]      cmd_addr_o;

  int total, bad, cycles;
  int cur_edge, flip_at, strb_cnt, cmd_cnt;
  logic [13:0] first_addr, last_addr;
  logic        mr_ok;

  wl_sweep_ctrl #(
    .TAP_W(TAP_W), .MAX_TAP(MAX_TAP), .FB_DLY(FB_DLY), .SETTLE(SETTLE),
    .QUAL(QUAL), .ADDR_W(14), .TMR_W(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .err_o(err_o), .found_tap_o(found_tap_o), .cmd_valid_o(cmd_valid_o),
    .cmd_mr_o(cmd_mr_o), .cmd_addr_o(cmd_addr_o), .odt_o(odt_o),
    .tap_o(tap_o), .strobe_o(strobe_o), .fb_i(fb_i)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: feedback per strobe, optional single flipped sample
  always @(negedge clk) begin
    cycles++;
    if (strobe_o) begin
      fb_i <= ((int'(tap_o) >= cur_edge) ? 1'b1 : 1'b0) ^ (strb_cnt == flip_at);
      strb_cnt++;
    end
    if (cmd_valid_o) begin
      if (cmd_mr_o != 3'd1) mr_ok = 1'b0;
      if (cmd_cnt == 0) first_addr = cmd_addr_o;
      last_addr = cmd_addr_o;
      cmd_cnt++;
    end
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input int e, input int flip, input int exp_strb,
                     input int exp_err, input int exp_tap);
    int wait_n;
    cur_edge = e; flip_at = flip; strb_cnt = 0; cmd_cnt = 0; mr_ok = 1'b1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R11 start clears done", int'(done_o), 0);
    check("R11 start clears err", int'(err_o), 0);
    check("R11 start clears found", int'(found_tap_o), 0);
    wait_n = 0;
    while (!done_o && wait_n < 3000) begin
      @(negedge clk); wait_n++;
    end
    check("R10 done reached", int'(done_o), 1);
    check("R10 err verdict", int'(err_o), exp_err);
    if (exp_err == 0) check("R9 found tap", int'(found_tap_o), exp_tap);
    check("R8 strobe count", strb_cnt, exp_strb);
    check("R3 command count", cmd_cnt, 2);
    check("R2 mr number", int'(mr_ok), 1);
    check("R2 entry bit7", int'(first_addr[7]), 1);
    check("R2 entry bit12", int'(first_addr[12]), 0);
    check("R3 exit bit7", int'(last_addr[7]), 0);
    check("R3 exit bit12", int'(last_addr[12]), 0);
    check("R4 odt off at done", int'(odt_o), 0);
    repeat (5) @(negedge clk);
    check("R11 done held", int'(done_o), 1);
    if (exp_err == 0) check("R11 found held", int'(found_tap_o), exp_tap);
  endtask

  initial begin
    total = 0; bad = 0; cycles = 0;
    cur_edge = 0; flip_at = -1; strb_cnt = 0; cmd_cnt = 0; mr_ok = 1'b1;
    first_addr = '0; last_addr = '0;
    start_i = 1'b0; fb_i = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done", int'(done_o), 0);
    check("R1 err", int'(err_o), 0);
    check("R1 cmd", int'(cmd_valid_o), 0);
    check("R1 odt", int'(odt_o), 0);
    check("R1 strobe", int'(strobe_o), 0);
    check("R1 tap", int'(tap_o), 0);
    check("R1 found", int'(found_tap_o), 0);
    // edge sweep: tap >= e reads 1
    for (int e = 0; e <= MAX_TAP + 1; e++) begin
      if (e >= 1 && e <= MAX_TAP)
        run(e, -1, (e + 1) * QUAL, 0, e);      // R9 transition at tap e
      else
        run(e, -1, (MAX_TAP + 1) * QUAL, 1, 0); // R10 no rising transition
    end
    // R8: one flipped sample at tap 3 restarts qualification
    run(3, 3 * QUAL + 1, 3 * QUAL + 4, 0, 3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule